// File: doc/BRIEF.md
# Bank Activate/Precharge Timing Tracker

This block keeps, for every bank of one rank, the earliest cycle at which the next activate, precharge or column command (read or write) may be issued to that bank. A scheduler places it beside its command arbiter and reports each granted activate or precharge to it as a grant event. The event carries the bank, the bank group of an activate, the cycle stamp of the grant, and, for a precharge, whether it was an explicit single-bank command or an auto/all-bank one. All allowed values are cycle stamps that only ever move later. The scheduler compares them against its own cycle counter.

Activates to a bank of the same group are spaced further apart than activates to a bank of another group. Only explicit precharges impose the precharge-to-precharge spacing on the whole rank. The block also keeps the stamps of the last four activates. From them it gives the earliest cycle at which a further activate fits the rolling activate window. An activate that breaks that window raises a sticky error flag. With `NUM_GROUPS` set to 0 (eight-bank mode), every activate uses the short spacing.

Every update lands on the clock edge that samples the grant and is visible from the following cycle.

Top module: `bt_timing_tracker`

## Requirements
- R1: After reset, every per-bank allowed value, `act_win_o` and `win_err_o` are 0.
- R2: An activate to bank b at stamp t raises bank b's precharge-allowed value to max(old, t + T_RAS).
- R3: An activate to bank b at stamp t raises bank b's column-allowed value to max(old, t + T_RCD).
- R4: An activate at stamp t in group g raises the activate-allowed value of every bank to max(old, t + T_RRD_L) when the bank's group (bank index / 4 at default sizes) equals g, and to max(old, t + T_RRD) otherwise.
- R5: An explicit precharge (`pre_expl_i` = 1) at stamp t raises every bank's precharge-allowed value to max(old, t + T_PPD). An auto or all-bank precharge (`pre_expl_i` = 0) changes no bank's precharge-allowed value.
- R6: A precharge to bank b at stamp t raises bank b's activate-allowed value to max(old, t + T_RP).
- R7: `act_win_o` is the oldest of the last four activate stamps plus T_XAW once four activates with nonzero stamps have been granted, and 0 before that. A stamp of 0 counts as an empty entry.
- R8: `win_err_o` rises after an activate whose stamp is below a nonzero `act_win_o`, and stays high until reset.
- R9: An activate and a precharge granted in the same cycle both take effect. Where both touch the same value, the larger result is kept.
- R10: With no grant, no output changes, and no allowed value ever decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| act_vld_i | input | 1 | Activate granted this cycle |
| act_bank_i | input | BANK_W | Bank of the activate |
| act_grp_i | input | GRP_W | Bank group of the activate |
| act_cyc_i | input | 16 | Cycle stamp of the activate |
| pre_vld_i | input | 1 | Precharge granted this cycle |
| pre_bank_i | input | BANK_W | Bank of the precharge |
| pre_expl_i | input | 1 | 1: explicit precharge, 0: auto or all-bank |
| pre_cyc_i | input | 16 | Cycle stamp of the precharge |
| act_ok_o | output | NUM_BANKS*16 | Per-bank earliest activate stamp, bank b at bits b*16 +: 16 |
| pre_ok_o | output | NUM_BANKS*16 | Per-bank earliest precharge stamp |
| col_ok_o | output | NUM_BANKS*16 | Per-bank earliest read/write stamp |
| act_win_o | output | 16 | Earliest activate stamp that fits the activate window, 0 if unconstrained |
| win_err_o | output | 1 | Sticky activate-window violation |

## Verification
An activate and a precharge can be granted in the same cycle. The bench does this by giving an activate to one bank and an explicit precharge to another bank of the same group in one cycle. The bank that is activated then receives both the T_RAS bound and the T_PPD bound on its precharge-allowed value. The precharged bank receives both the T_RRD_L bound and the T_RP bound on its activate-allowed value. The scoreboard model computes each bound on its own and keeps the maximum, so an update that drops one of the two paths shows up as a mismatch in the affected bank slot.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int CYC_W = 16;
  typedef logic [CYC_W-1:0] cyc_t;

  function automatic cyc_t cyc_max(input cyc_t a, input cyc_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bt_bank_slot.sv
module bt_bank_slot
  import bt_pkg::*;
#(
  parameter int   BANK_W = 4,
  parameter int   GRP_W  = 2,
  parameter int   IDX    = 0,
  parameter int   MY_GRP = 0,
  parameter bit   GRP_EN = 1'b1,
  parameter cyc_t RAS    = '0,
  parameter cyc_t RCD    = '0,
  parameter cyc_t RRD    = '0,
  parameter cyc_t RRD_L  = '0,
  parameter cyc_t PPD    = '0,
  parameter cyc_t RP     = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_vld_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [GRP_W-1:0]  act_grp_i,
  input  cyc_t              act_cyc_i,
  input  logic              pre_vld_i,
  input  logic [BANK_W-1:0] pre_bank_i,
  input  logic              pre_expl_i,
  input  cyc_t              pre_cyc_i,
  output cyc_t              act_ok_o,
  output cyc_t              pre_ok_o,
  output cyc_t              col_ok_o
);
  cyc_t act_q, pre_q, col_q;
  cyc_t act_n, pre_n, col_n;
  logic act_hit, pre_hit, grp_hit;

  assign act_hit = act_vld_i && (act_bank_i == BANK_W'(IDX));
  assign pre_hit = pre_vld_i && (pre_bank_i == BANK_W'(IDX));
  assign grp_hit = GRP_EN && (act_grp_i == GRP_W'(MY_GRP));

  always_comb begin
    act_n = act_q;
    pre_n = pre_q;
    col_n = col_q;
    if (act_vld_i) act_n = cyc_max(act_n, act_cyc_i + (grp_hit ? RRD_L : RRD));
    if (pre_hit)   act_n = cyc_max(act_n, pre_cyc_i + RP);
    if (act_hit) begin
      pre_n = cyc_max(pre_n, act_cyc_i + RAS);
      col_n = cyc_max(col_n, act_cyc_i + RCD);
    end
    // only explicit precharges space the rank's precharges
    if (pre_vld_i && pre_expl_i) pre_n = cyc_max(pre_n, pre_cyc_i + PPD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      pre_q <= '0;
      col_q <= '0;
    end else begin
      act_q <= act_n;
      pre_q <= pre_n;
      col_q <= col_n;
    end
  end

  assign act_ok_o = act_q;
  assign pre_ok_o = pre_q;
  assign col_ok_o = col_q;
endmodule

// File: rtl/bt_act_window.sv
module bt_act_window
  import bt_pkg::*;
#(
  parameter int   ACT_LIMIT = 4,
  parameter cyc_t XAW       = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_vld_i,
  input  cyc_t act_cyc_i,
  output cyc_t win_o,
  output logic err_o
);
  cyc_t hist_q [ACT_LIMIT];
  logic err_q;
  logic full;
  logic viol;

  assign full  = (hist_q[ACT_LIMIT-1] != '0);
  assign win_o = full ? hist_q[ACT_LIMIT-1] + XAW : '0;
  assign viol  = act_vld_i && full && (act_cyc_i < win_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q[0] <= '0;
    else if (act_vld_i) hist_q[0] <= act_cyc_i;
  end

  for (genvar i = 1; i < ACT_LIMIT; i++) begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[i] <= '0;
      else if (act_vld_i) hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (viol) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/bt_timing_tracker.sv
module bt_timing_tracker
  import bt_pkg::*;
#(
  parameter int NUM_BANKS  = 16,
  parameter int NUM_GROUPS = 4,
  parameter int T_RAS      = 30,
  parameter int T_RCD      = 13,
  parameter int T_RRD      = 4,
  parameter int T_RRD_L    = 6,
  parameter int T_XAW      = 20,
  parameter int T_PPD      = 2,
  parameter int T_RP       = 13,
  parameter int ACT_LIMIT  = 4,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BUS_W     = NUM_BANKS * CYC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_vld_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [GRP_W-1:0]  act_grp_i,
  input  logic [CYC_W-1:0]  act_cyc_i,
  input  logic              pre_vld_i,
  input  logic [BANK_W-1:0] pre_bank_i,
  input  logic              pre_expl_i,
  input  logic [CYC_W-1:0]  pre_cyc_i,
  output logic [BUS_W-1:0]  act_ok_o,
  output logic [BUS_W-1:0]  pre_ok_o,
  output logic [BUS_W-1:0]  col_ok_o,
  output logic [CYC_W-1:0]  act_win_o,
  output logic              win_err_o
);
  localparam bit GRP_EN        = (NUM_GROUPS > 0);
  localparam int BANKS_PER_GRP = GRP_EN ? NUM_BANKS / NUM_GROUPS : NUM_BANKS;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bt_bank_slot #(
      .BANK_W (BANK_W),
      .GRP_W  (GRP_W),
      .IDX    (b),
      .MY_GRP (b / BANKS_PER_GRP),
      .GRP_EN (GRP_EN),
      .RAS    (cyc_t'(T_RAS)),
      .RCD    (cyc_t'(T_RCD)),
      .RRD    (cyc_t'(T_RRD)),
      .RRD_L  (cyc_t'(GRP_EN ? T_RRD_L : T_RRD)),
      .PPD    (cyc_t'(T_PPD)),
      .RP     (cyc_t'(T_RP))
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_vld_i  (act_vld_i),
      .act_bank_i (act_bank_i),
      .act_grp_i  (act_grp_i),
      .act_cyc_i  (act_cyc_i),
      .pre_vld_i  (pre_vld_i),
      .pre_bank_i (pre_bank_i),
      .pre_expl_i (pre_expl_i),
      .pre_cyc_i  (pre_cyc_i),
      .act_ok_o   (act_ok_o[b*CYC_W +: CYC_W]),
      .pre_ok_o   (pre_ok_o[b*CYC_W +: CYC_W]),
      .col_ok_o   (col_ok_o[b*CYC_W +: CYC_W])
    );
  end

  bt_act_window #(
    .ACT_LIMIT (ACT_LIMIT),
    .XAW       (cyc_t'(T_XAW))
  ) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_vld_i (act_vld_i),
    .act_cyc_i (act_cyc_i),
    .win_o     (act_win_o),
    .err_o     (win_err_o)
  );
endmodule

// File: rtl/bt_timing_tracker_chk.sv
module bt_timing_tracker_chk
  import bt_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int T_RAS     = 30,
  parameter int T_RCD     = 13,
  parameter int T_RP      = 13
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       act_vld_i,
  input logic [BANK_W-1:0]          act_bank_i,
  input logic [CYC_W-1:0]           act_cyc_i,
  input logic                       pre_vld_i,
  input logic [BANK_W-1:0]          pre_bank_i,
  input logic [CYC_W-1:0]           pre_cyc_i,
  input logic [NUM_BANKS*CYC_W-1:0] act_ok_o,
  input logic [NUM_BANKS*CYC_W-1:0] pre_ok_o,
  input logic [NUM_BANKS*CYC_W-1:0] col_ok_o,
  input logic [CYC_W-1:0]           act_win_o,
  input logic                       win_err_o
);
  localparam cyc_t RAS_C = cyc_t'(T_RAS);
  localparam cyc_t RCD_C = cyc_t'(T_RCD);
  localparam cyc_t RP_C  = cyc_t'(T_RP);

  p_pre_ras_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_i |=> pre_ok_o[$past(act_bank_i)*CYC_W +: CYC_W] >= cyc_t'($past(act_cyc_i) + RAS_C));

  p_col_rcd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_i |=> col_ok_o[$past(act_bank_i)*CYC_W +: CYC_W] >= cyc_t'($past(act_cyc_i) + RCD_C));

  p_act_rp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_vld_i |=> act_ok_o[$past(pre_bank_i)*CYC_W +: CYC_W] >= cyc_t'($past(pre_cyc_i) + RP_C));

  p_win_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_err_o && (!act_vld_i || act_win_o == '0 || act_cyc_i >= act_win_o)) |=> !win_err_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_err_o |=> win_err_o);

  p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_vld_i && !pre_vld_i) |=> ($stable(act_ok_o) && $stable(pre_ok_o) && $stable(col_ok_o)
                                    && $stable(act_win_o)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mono
    p_no_decrease_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (act_ok_o[b*CYC_W +: CYC_W] >= $past(act_ok_o[b*CYC_W +: CYC_W]))
            && (pre_ok_o[b*CYC_W +: CYC_W] >= $past(pre_ok_o[b*CYC_W +: CYC_W]))
            && (col_ok_o[b*CYC_W +: CYC_W] >= $past(col_ok_o[b*CYC_W +: CYC_W])));
  end
endmodule

bind bt_timing_tracker bt_timing_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .T_RAS     (T_RAS),
  .T_RCD     (T_RCD),
  .T_RP      (T_RP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_vld_i  (act_vld_i),
  .act_bank_i (act_bank_i),
  .act_cyc_i  (act_cyc_i),
  .pre_vld_i  (pre_vld_i),
  .pre_bank_i (pre_bank_i),
  .pre_cyc_i  (pre_cyc_i),
  .act_ok_o   (act_ok_o),
  .pre_ok_o   (pre_ok_o),
  .col_ok_o   (col_ok_o),
  .act_win_o  (act_win_o),
  .win_err_o  (win_err_o)
);

// File: tb/bt_timing_tracker_tb_top.sv
module bt_timing_tracker_tb_top;
  localparam int NB = 16;
  localparam int BPG = 4;
  localparam int RAS = 30, RCD = 13, RRD = 4, RRD_L = 6, XAW = 20, PPD = 2, RP = 13;

  typedef struct {
    int          kind;   // 0 act,1 pre,2 col,3 win,4 err
    int          bank;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_vld = 1'b0, pre_vld = 1'b0, pre_expl = 1'b0;
  logic [3:0]  act_bank = '0, pre_bank = '0;
  logic [1:0]  act_grp = '0;
  logic [15:0] act_cyc = '0, pre_cyc = '0;
  logic [NB*16-1:0] act_ok, pre_ok, col_ok;
  logic [15:0] act_win;
  logic        win_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  logic [15:0] m_act[NB], m_pre[NB], m_col[NB], m_hist[4];
  logic        m_err;

  always #4 clk = ~clk;

  bt_timing_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .act_vld_i(act_vld), .act_bank_i(act_bank), .act_grp_i(act_grp), .act_cyc_i(act_cyc),
    .pre_vld_i(pre_vld), .pre_bank_i(pre_bank), .pre_expl_i(pre_expl), .pre_cyc_i(pre_cyc),
    .act_ok_o(act_ok), .pre_ok_o(pre_ok), .col_ok_o(col_ok),
    .act_win_o(act_win), .win_err_o(win_err)
  );

  function automatic logic [15:0] mx(input logic [15:0] a, input logic [15:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [15:0] m_win();
    return (m_hist[3] != 0) ? m_hist[3] + 16'(XAW) : 16'd0;
  endfunction

  task automatic push_all(input string req);
    for (int b = 0; b < NB; b++) begin
      sb_q.push_back('{0, b, m_act[b], req});
      sb_q.push_back('{1, b, m_pre[b], req});
      sb_q.push_back('{2, b, m_col[b], req});
    end
    sb_q.push_back('{3, 0, m_win(), req});
    sb_q.push_back('{4, 0, {15'd0, m_err}, req});
  endtask

  // driver: one grant cycle, model update, expected snapshot queued
  task automatic grant(input bit av, input int ab, input int ac,
                       input bit pv, input int pb, input int pc, input bit pe,
                       input string req);
    @(negedge clk);
    act_vld = av; act_bank = 4'(ab); act_grp = 2'(ab / BPG); act_cyc = 16'(ac);
    pre_vld = pv; pre_bank = 4'(pb); pre_cyc = 16'(pc); pre_expl = pe;
    if (av) begin
      if (m_hist[3] != 0 && 16'(ac) < m_win()) m_err = 1'b1;
      for (int b = 0; b < NB; b++)
        m_act[b] = mx(m_act[b], 16'(ac + (((b / BPG) == (ab / BPG)) ? RRD_L : RRD)));
      m_pre[ab] = mx(m_pre[ab], 16'(ac + RAS));
      m_col[ab] = mx(m_col[ab], 16'(ac + RCD));
      for (int i = 3; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = 16'(ac);
    end
    if (pv) begin
      m_act[pb] = mx(m_act[pb], 16'(pc + RP));
      if (pe) for (int b = 0; b < NB; b++) m_pre[b] = mx(m_pre[b], 16'(pc + PPD));
    end
    push_all(req);
    @(negedge clk);
    act_vld = 1'b0; pre_vld = 1'b0;
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    push_all(req);
    @(negedge clk);
  endtask

  // monitor: compares just after the edge that registered the grant
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          0: got = act_ok[it.bank*16 +: 16];
          1: got = pre_ok[it.bank*16 +: 16];
          2: got = col_ok[it.bank*16 +: 16];
          3: got = act_win;
          default: got = {15'd0, win_err};
        endcase
        n_checks++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d bank=%0d actual=%0d expected=%0d",
                   it.req, it.kind, it.bank, got, it.exp);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_act[b] = 0; m_pre[b] = 0; m_col[b] = 0; end
    for (int i = 0; i < 4; i++) m_hist[i] = 0;
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    grant(1, 5, 10, 0, 0, 0, 0, "R2 R3 R4");
    // activate bank 4 and explicit precharge bank 5 (same group) together
    grant(1, 4, 20, 1, 5, 40, 1, "R9 R5 R6");
    // auto precharge: precharge-allowed must stay untouched
    grant(0, 0, 0, 1, 9, 50, 0, "R5 R6");
    // activate in another group
    grant(1, 13, 60, 0, 0, 0, 0, "R4 R7");
    idle("R10");
    grant(1, 2, 100, 0, 0, 0, 0, "R7");
    grant(1, 6, 104, 0, 0, 0, 0, "R7");
    grant(1, 10, 108, 0, 0, 0, 0, "R7");
    grant(1, 14, 112, 0, 0, 0, 0, "R7");
    // window fits exactly: 100 + 20 = 120 is allowed
    grant(1, 3, 120, 0, 0, 0, 0, "R8");
    // 121 < 104 + 20 violates
    grant(1, 7, 121, 1, 2, 130, 1, "R8 R9");
    idle("R8 R10");
    grant(1, 0, 200, 0, 0, 0, 0, "R8 R4");
    idle("R10");
    done = 1'b1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule